// File: doc/BRIEF.md
# Fault-Correcting Pipelined Byte Substitution Unit

This block computes the AES forward substitution of one byte per clock. The byte is mapped into a composite field GF((2^4)^2) and inverted there, then mapped back and passed through the AES affine transform. The datapath is cut into four register stages: input field mapping; square, scale and multiply of the nibble halves; GF(2^4) inversion; and final multiply with inverse mapping and affine step.

Each stage is built twice. The two copies see the same input, and a comparator raises a per-stage error flag when their results differ. While any flag is raised, the whole pipeline stops advancing. Every stage register keeps its last good contents, no new byte is taken, and the stage that disagrees keeps re-evaluating its held input. Traffic resumes on the first cycle in which the copies match again. A transient upset of any length is therefore corrected rather than only reported. A per-stage XOR mask acting on the second copy lets a test bench create such disagreements at will.

Top module: `ft_sbox_pipe`

## Requirements
- R1: For every accepted byte x, out_byte equals the AES forward S-box of x; in particular 0x00 gives 0x63, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With no error flag raised, in_ready is 1, a byte is accepted on every rising edge where in_valid is 1, and its result is presented with out_valid = 1 in the cycle that follows the fourth rising edge, counting the accepting edge as the first.
- R3: stage_err[k] is 1 exactly when stage k has valid data at its input and its two copies disagree. Stage 0 is the input mapping and stage 3 the final one, and fault_mask[8k+7:8k] is XORed onto copy two of stage k. A non-zero mask on a stage with no valid data at its input raises no flag.
- R4: While any bit of stage_err is 1, stall is 1 and in_ready is 0, and no byte is accepted.
- R5: While stalled, the pipeline holds its contents and out_valid stays 0. Across a fault of any length (exercised from 1 to 20 cycles), no byte is lost, duplicated or reordered.
- R6: In the first cycle after every copy agrees again, stall returns to 0 and the pipeline resumes. Bytes that were in flight during the fault come out with correct values.
- R7: Disagreements in several stages at once, overlapping or coincident, are corrected in the same way.
- R8: A synchronous active-high reset empties the pipeline. After it, out_valid is 0, stall is 0, stage_err is 0 and in_ready is 1, and no byte taken before the reset is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_byte | input | 8 | Byte to substitute |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is 1 |
| out_valid | output | 1 | One-cycle pulse per result |
| out_byte | output | 8 | Substituted byte |
| fault_mask | input | 32 | Per-stage XOR mask on copy two, 8 bits per stage, stage k at bits 8k+7:8k |
| stage_err | output | 4 | Per-stage disagreement flags, bit k for stage k |
| stall | output | 1 | Pipeline frozen for correction |

## Verification
Two events can fall in the same cycle. A new byte can be offered just as a stage starts to disagree, and stage 3 can be about to emit a result in the cycle a fault appears. The bench streams bytes back to back and raises masks on chosen stages at chosen cycles, alone and overlapping, so that both collisions occur. Each case is judged against a reference table that is computed independently in the bench. The bench checks that every offered byte is accepted exactly once, that results come out in order with correct values, that out_valid is silent in the cycle after every stalled cycle, and that input and output counts match after draining.

// File: rtl/ft_sbox_pkg.sv
package ft_sbox_pkg;

    localparam int NSTAGE = 4;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int SDAT_W = 3 * NIB_W;
    localparam int MASK_W = NSTAGE * BYTE_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic              vld;
        logic [SDAT_W-1:0] dat;
    } slot_t;

    typedef struct packed {
        slot_t [NSTAGE-1:0] st;
    } pipe_t;

    // GF(2^4) product, field polynomial x^4 + x + 1
    function automatic nib_t gf4_mul(nib_t a, nib_t b);
        nib_t acc;
        nib_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    function automatic nib_t gf4_sq(nib_t a);
        return gf4_mul(a, a);
    endfunction

    // a^14 is the inverse in GF(16); zero stays zero
    function automatic nib_t gf4_inv(nib_t a);
        nib_t a2, a4, a8;
        a2 = gf4_sq(a);
        a4 = gf4_sq(a2);
        a8 = gf4_sq(a4);
        return gf4_mul(gf4_mul(a8, a4), a2);
    endfunction

    // smallest constant that makes y^2 + y + c irreducible over GF(16)
    function automatic nib_t find_lambda();
        nib_t res;
        logic found;
        logic has_root;
        res   = '0;
        found = 1'b0;
        for (int c = 1; c < 16; c++) begin
            has_root = 1'b0;
            for (int t = 0; t < 16; t++) begin
                if ((gf4_sq(4'(t)) ^ 4'(t)) == 4'(c)) has_root = 1'b1;
            end
            if (!has_root && !found) begin
                res   = 4'(c);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    localparam nib_t LAMBDA = find_lambda();

    // composite-field product, element = hi*y + lo, y^2 = y + LAMBDA
    function automatic byte_t gfc_mul(byte_t a, byte_t b);
        nib_t hh;
        byte_t r;
        hh = gf4_mul(a[7:4], b[7:4]);
        r[7:4] = hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]);
        r[3:0] = gf4_mul(hh, LAMBDA) ^ gf4_mul(a[3:0], b[3:0]);
        return r;
    endfunction

    // linear map given by its eight columns
    function automatic byte_t mat_apply(logic [BYTE_W*BYTE_W-1:0] cols, byte_t v);
        byte_t r;
        r = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (v[i]) r = r ^ cols[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    // columns are powers of a root of the AES polynomial in the composite field
    function automatic logic [BYTE_W*BYTE_W-1:0] iso_cols();
        logic [BYTE_W*BYTE_W-1:0] cols;
        byte_t beta, c, c2, c3, c4, c8, p;
        logic found;
        beta  = 8'h02;
        found = 1'b0;
        for (int k = 2; k < 256; k++) begin
            c  = 8'(k);
            c2 = gfc_mul(c, c);
            c3 = gfc_mul(c2, c);
            c4 = gfc_mul(c2, c2);
            c8 = gfc_mul(c4, c4);
            p  = c8 ^ c4 ^ c3 ^ c ^ 8'h01;
            if (p == 8'h00 && !found) begin
                beta  = c;
                found = 1'b1;
            end
        end
        p = 8'h01;
        for (int i = 0; i < BYTE_W; i++) begin
            cols[i*BYTE_W +: BYTE_W] = p;
            p = gfc_mul(p, beta);
        end
        return cols;
    endfunction

    localparam logic [BYTE_W*BYTE_W-1:0] ISO_COLS = iso_cols();

    function automatic logic [BYTE_W*BYTE_W-1:0] iso_inv_cols();
        logic [BYTE_W*BYTE_W-1:0] res;
        byte_t t;
        res = '0;
        for (int v = 0; v < 256; v++) begin
            t = mat_apply(ISO_COLS, 8'(v));
            for (int j = 0; j < BYTE_W; j++) begin
                if (t == (8'h01 << j)) res[j*BYTE_W +: BYTE_W] = 8'(v);
            end
        end
        return res;
    endfunction

    localparam logic [BYTE_W*BYTE_W-1:0] ISO_INV_COLS = iso_inv_cols();

    function automatic byte_t aes_affine(byte_t x);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = x[i] ^ x[(i+4)%BYTE_W] ^ x[(i+5)%BYTE_W]
                 ^ x[(i+6)%BYTE_W] ^ x[(i+7)%BYTE_W];
        end
        return r ^ 8'h63;
    endfunction

endpackage

// File: rtl/ft_sbox_stage.sv
module ft_sbox_stage
    import ft_sbox_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [SDAT_W-1:0] in_dat,
    input  logic [BYTE_W-1:0] flip,
    output logic [SDAT_W-1:0] out_dat
);

    localparam int PAD_W = SDAT_W - BYTE_W;

    logic [SDAT_W-1:0] raw;

    generate
        if (IDX == 0) begin : g_map
            logic unused_hi;
            assign unused_hi = ^in_dat[SDAT_W-1:BYTE_W];
            always_comb begin
                raw = {{PAD_W{1'b0}}, mat_apply(ISO_COLS, in_dat[BYTE_W-1:0])};
            end
        end else if (IDX == 1) begin : g_norm
            logic unused_hi;
            nib_t ah, al, dl;
            assign unused_hi = ^in_dat[SDAT_W-1:BYTE_W];
            always_comb begin
                ah  = in_dat[2*NIB_W-1:NIB_W];
                al  = in_dat[NIB_W-1:0];
                dl  = gf4_mul(gf4_sq(ah), LAMBDA) ^ gf4_mul(ah, al) ^ gf4_sq(al);
                raw = {ah, al, dl};
            end
        end else if (IDX == 2) begin : g_inv
            nib_t dl, di;
            always_comb begin
                dl  = in_dat[NIB_W-1:0];
                di  = gf4_inv(dl);
                raw = {in_dat[SDAT_W-1:NIB_W], di};
            end
            always_comb begin
                if (dl != '0) begin
                    assert_nib_inverse_R1 : assert (gf4_mul(dl, di) == 4'h1);
                end
            end
        end else begin : g_out
            nib_t ah, al, di;
            byte_t prod;
            always_comb begin
                ah   = in_dat[3*NIB_W-1:2*NIB_W];
                al   = in_dat[2*NIB_W-1:NIB_W];
                di   = in_dat[NIB_W-1:0];
                prod = {gf4_mul(ah, di), gf4_mul(ah ^ al, di)};
                raw  = {{PAD_W{1'b0}}, aes_affine(mat_apply(ISO_INV_COLS, prod))};
            end
        end
    endgenerate

    assign out_dat = raw ^ {{PAD_W{1'b0}}, flip};

endmodule

// File: rtl/ft_sbox_ctrl.sv
module ft_sbox_ctrl #(
    parameter int N = 4
) (
    input  logic [N-1:0] err,
    output logic         stall,
    output logic         in_ready
);

    always_comb begin
        stall    = |err;
        in_ready = ~stall;
    end

endmodule

// File: rtl/ft_sbox_pipe.sv
module ft_sbox_pipe
    import ft_sbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    input  logic [MASK_W-1:0] fault_mask,
    output logic [NSTAGE-1:0] stage_err,
    output logic              stall
);

    localparam int PAD_W = SDAT_W - BYTE_W;

    pipe_t pipe_d, pipe_q;

    logic [SDAT_W-1:0] src_dat [NSTAGE];
    logic              src_vld [NSTAGE];
    logic [SDAT_W-1:0] res_a   [NSTAGE];
    logic [SDAT_W-1:0] res_b   [NSTAGE];

    genvar k;
    generate
        for (k = 0; k < NSTAGE; k++) begin : g_stage
            if (k == 0) begin : g_src_in
                assign src_dat[k] = {{PAD_W{1'b0}}, in_byte};
                assign src_vld[k] = in_valid;
            end else begin : g_src_reg
                assign src_dat[k] = pipe_q.st[k-1].dat;
                assign src_vld[k] = pipe_q.st[k-1].vld;
            end

            ft_sbox_stage #(.IDX(k)) u_cpy_a (
                .in_dat (src_dat[k]),
                .flip   ({BYTE_W{1'b0}}),
                .out_dat(res_a[k])
            );

            ft_sbox_stage #(.IDX(k)) u_cpy_b (
                .in_dat (src_dat[k]),
                .flip   (fault_mask[k*BYTE_W +: BYTE_W]),
                .out_dat(res_b[k])
            );

            assign stage_err[k] = src_vld[k] & (res_a[k] != res_b[k]);

            // identical copies can only part through an injected mask
            assert_err_from_mask_R3 : assert property (@(posedge clk) disable iff (rst)
                stage_err[k] |-> (fault_mask[k*BYTE_W +: BYTE_W] != '0));
        end
    endgenerate

    ft_sbox_ctrl #(.N(NSTAGE)) u_ctrl (
        .err     (stage_err),
        .stall   (stall),
        .in_ready(in_ready)
    );

    always_comb begin
        pipe_d = pipe_q;
        if (!stall) begin
            for (int s = 0; s < NSTAGE; s++) begin
                pipe_d.st[s].vld = src_vld[s];
                pipe_d.st[s].dat = res_a[s];
            end
        end else begin
            pipe_d.st[NSTAGE-1].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.st[NSTAGE-1].vld;
    assign out_byte  = pipe_q.st[NSTAGE-1].dat[BYTE_W-1:0];

    logic unused_top;
    assign unused_top = ^pipe_q.st[NSTAGE-1].dat[SDAT_W-1:BYTE_W];

    assert_hold_on_stall_R5 : assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pipe_q.st[NSTAGE-2:0]));

    assert_silent_on_stall_R5 : assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    assert_accept_loads_R2 : assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> pipe_q.st[0].vld);

    assert_blocked_input_R4 : assert property (@(posedge clk) disable iff (rst)
        (stage_err != '0) |-> (!in_ready && stall));

    assert_reset_empty_R8 : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/ft_sbox_pipe_bench.sv
`timescale 1ns/1ps
module ft_sbox_pipe_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [31:0] fault_mask = '0;
    logic [3:0]  stage_err;
    logic        stall;

    always #10 clk = ~clk;

    ft_sbox_pipe u_ft_sbox_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte),
        .fault_mask(fault_mask), .stage_err(stage_err), .stall(stall)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_in  = 0;
    int n_out = 0;
    bit done  = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] ref_tab [256];
    logic [7:0] exp_q [$];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            ref_tab[x] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3)
                       ^ rotl(inv, 4) ^ 8'h63;
        end
    end

    // scoreboard, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                n_out++;
                if (prev_stall) chk("R5 out_valid after stalled cycle", 1, 0);
                if (exp_q.size() == 0) chk("R5 unexpected output", 1, 0);
                else chk("R1 R6 output value", out_byte, exp_q.pop_front());
            end
            if (in_valid && in_ready) begin
                n_in++;
                exp_q.push_back(ref_tab[in_byte]);
            end
            prev_stall = stall;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic drain();
        int lim = 0;
        in_valid = 1'b0;
        while ((exp_q.size() != 0) && lim < 60) begin
            @(negedge clk);
            lim++;
        end
        repeat (2) @(negedge clk);
        chk("R5 queue empty after drain", exp_q.size(), 0);
        chk("R5 in/out count", n_out, n_in);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R8 out_valid after reset", out_valid, 0);
        chk("R8 in_ready after reset", in_ready, 1);
        chk("R8 stall after reset", stall, 0);
        chk("R8 stage_err after reset", stage_err, 0);
    endtask

    task automatic t_single(logic [7:0] b, logic [7:0] lit);
        int n = 0;
        @(posedge clk); #2;
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        chk("R2 in_ready idle", in_ready, 1);
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk); n = 1;
        while (!out_valid && n < 10) begin
            @(negedge clk); n++;
        end
        chk("R2 latency", n, 4);
        chk("R1 known value", out_byte, lit);
    endtask

    task automatic t_stream_all();
        int busy = 0;
        for (int i = 0; i < 256; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1; in_byte = 8'(i);
            @(negedge clk);
            if (!in_ready) busy++;
        end
        @(posedge clk); #2;
        chk("R2 back-to-back acceptance", busy, 0);
        drain();
    endtask

    // stream nbytes; masks m0/m1 on stages s0/s1 over windows [a0,a0+l0) and [a1,a1+l1)
    task automatic t_fault(string tag, int nbytes, int seed,
                           int s0, int a0, int l0, int s1, int a1, int l1);
        int idx = 0;
        int cyc = 0;
        bit was = 1'b0;
        while (idx < nbytes || cyc < a0 + l0 + 2 || cyc < a1 + l1 + 2) begin
            bit w0, w1;
            @(posedge clk); #2;
            w0 = (cyc >= a0) && (cyc < a0 + l0);
            w1 = (cyc >= a1) && (cyc < a1 + l1);
            fault_mask = '0;
            if (w0) fault_mask[s0*8 +: 8] = 8'h5A;
            if (w1) fault_mask[s1*8 +: 8] |= 8'hC3;
            in_valid = (idx < nbytes);
            in_byte  = 8'(idx * 37 + seed);
            @(negedge clk);
            if (w0) chk({tag, " R3 flag of faulty stage"}, stage_err[s0], 1);
            if (w1) chk({tag, " R7 flag of second stage"}, stage_err[s1], 1);
            if (w0 || w1) begin
                chk({tag, " R4 stall"}, stall, 1);
                chk({tag, " R4 in_ready low"}, in_ready, 0);
            end else if (was) begin
                chk({tag, " R6 resume"}, stall, 0);
            end
            was = w0 || w1;
            if (in_valid && in_ready) idx++;
            cyc++;
        end
        @(posedge clk); #2;
        fault_mask = '0;
        drain();
    endtask

    task automatic t_idle_mask();
        in_valid = 1'b0;
        repeat (6) @(posedge clk);
        #2 fault_mask = '1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 idle mask no flag", stage_err, 0);
            chk("R3 idle mask no stall", stall, 0);
            chk("R3 idle mask ready", in_ready, 1);
            chk("R3 idle mask no output", out_valid, 0);
            @(posedge clk); #2;
        end
        fault_mask = '0;
    endtask

    task automatic t_midreset();
        int seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1; in_byte = 8'(i + 90);
            @(negedge clk);
        end
        @(posedge clk); #2;
        in_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        exp_q.delete();
        n_in = 0; n_out = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk("R8 no stale output after reset", seen, 0);
        chk("R8 ready after mid-run reset", in_ready, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_single(8'h00, 8'h63);
        t_single(8'h01, 8'h7C);
        t_single(8'h53, 8'hED);
        t_stream_all();
        t_fault("s0x1",  16, 3,  0, 5, 1,  0, 0, 0);
        t_fault("s1x3",  16, 11, 1, 5, 3,  1, 0, 0);
        t_fault("s2x20", 24, 29, 2, 6, 20, 2, 0, 0);
        t_fault("s3x7",  16, 51, 3, 4, 7,  3, 0, 0);
        t_fault("s1s3",  16, 77, 1, 5, 5,  3, 5, 5);
        t_fault("s0s2",  20, 5,  0, 4, 4,  2, 6, 5);
        t_idle_mask();
        t_midreset();
        t_fault("post",  12, 200, 2, 3, 2, 2, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

endmodule